// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and owns the command pins from reset until the memory is ready for ordinary traffic. It drives a no-operation period long enough for supply and clock to settle. It then precharges every bank, runs a configurable number of auto-refresh cycles and loads the mode register. After the mode-load recovery time it raises a ready flag that the rest of the controller waits for before it takes over the pins.

Every wait is given in nanoseconds and converted to whole clock cycles by rounding up, using a clock-period parameter (10 ns by default). The mode-register contents come from three static inputs: a burst-length code, a burst-type select and a latency select. A synchronous reset at any point abandons the sequence and starts it again from the quiet period.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high and whenever no command is being issued, the pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111) with `addr` and `ba` zero. `cke` is always 1, every `dqm` bit is always 1, and `init_done` is 0 in reset.
- R2: The first command after reset appears at rising edge NQ counted from reset release, where NQ = ceil(T_QUIET_NS / period). Only NOP is driven before that edge.
- R3: That first command is precharge-all, encoded as 0010 with `addr[10]` = 1, every other address bit 0 and `ba` = 0.
- R4: The first auto-refresh (0001, `addr` and `ba` zero) appears exactly NRP = ceil(T_RP_NS / period) edges after the precharge-all.
- R5: Exactly REFRESH_COUNT auto-refresh commands are issued, each NRC = ceil(T_RC_NS / period) edges after the one before it.
- R6: A mode-register load (0000, `ba` = 0, `addr[11:7]` = 0) appears NRC edges after the last refresh.
- R7: Mode word bits 2:0 carry `mode_bl` unchanged (0 = 1, 1 = 2, 2 = 4, 3 = 8, 7 = whole row).
- R8: Mode word bit 3 carries `mode_interleave` (0 = sequential, 1 = interleaved).
- R9: Mode word bits 6:4 are 010 when `mode_cl3` = 0 and 011 when `mode_cl3` = 1.
- R10: `init_done` rises exactly NMRD = ceil(T_MRD_NS / period) edges after the mode load. It then stays high until reset, and only NOP is driven while it is high.
- R11: A reset that is high on the edge where a command would otherwise appear suppresses that command, giving NOP with `init_done` low. The next release restarts the whole sequence from R2.
- R12: A wait whose length in nanoseconds is not a whole number of periods rounds up to the next cycle, and a nonzero wait is never shorter than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_bl | input | 3 | Burst-length code for the mode word |
| mode_interleave | input | 1 | Burst type: 1 = interleaved |
| mode_cl3 | input | 1 | Latency select: 0 = 2, 1 = 3 |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row/mode address bus |
| dqm | output | DQM_W | Data masks, held high |
| init_done | output | 1 | Memory ready for normal commands |

## Verification
The collision that matters here is a synchronous reset landing on the same clock edge at which the step timer expires and a command would be driven. The bench raises reset for exactly the edge of the precharge-all, of one mid-sequence refresh and of the mode load. It requires NOP and a low ready flag on that edge, and it requires a complete, correctly timed sequence after the next release. Every cycle of every run, over all legal mode combinations, is compared against a schedule the bench derives from the rounded-up waits.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_QUIET,
    ST_PRE_WAIT,
    ST_REF_WAIT,
    ST_MODE_WAIT,
    ST_READY
  } step_e;

  typedef enum logic [1:0] {
    ISS_NOP,
    ISS_PREA,
    ISS_REFRESH,
    ISS_MODE
  } issue_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP  = 4'b0111;
  localparam pins_t PINS_PREA = 4'b0010;
  localparam pins_t PINS_REF  = 4'b0001;
  localparam pins_t PINS_MODE = 4'b0000;

  // Round a nanosecond interval up to whole clock cycles, at least one.
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned period_ps);
    longint unsigned num;
    longint unsigned q;
    num = longint'(t_ns) * 64'd1000;
    q   = (num + longint'(period_ps) - 64'd1) / longint'(period_ps);
    if (q == 64'd0) q = 64'd1;
    return int'(q);
  endfunction

  function automatic pins_t issue_pins(input issue_e kind);
    case (kind)
      ISS_PREA:    return PINS_PREA;
      ISS_REFRESH: return PINS_REF;
      ISS_MODE:    return PINS_MODE;
      default:     return PINS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned TW       = 16,
  parameter int unsigned RST_LOAD = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= TW'(RST_LOAD);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int unsigned TW            = 16,
  parameter int unsigned RW            = 4,
  parameter int unsigned N_RP          = 2,
  parameter int unsigned N_RC          = 7,
  parameter int unsigned N_MRD         = 2,
  parameter int unsigned REFRESH_COUNT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          expired,
  output logic          load,
  output logic [TW-1:0] load_val,
  output issue_e        issue,
  output logic          finish
);

  step_e         step_q, step_d;
  logic [RW-1:0] refs_left_q, refs_left_d;

  always_comb begin
    step_d      = step_q;
    refs_left_d = refs_left_q;
    load        = 1'b0;
    load_val    = '0;
    issue       = ISS_NOP;
    finish      = 1'b0;
    case (step_q)
      ST_QUIET: begin
        if (expired) begin
          issue    = ISS_PREA;
          load     = 1'b1;
          load_val = TW'(N_RP - 1);
          step_d   = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: begin
        if (expired) begin
          issue       = ISS_REFRESH;
          load        = 1'b1;
          load_val    = TW'(N_RC - 1);
          refs_left_d = RW'(REFRESH_COUNT - 1);
          step_d      = ST_REF_WAIT;
        end
      end
      ST_REF_WAIT: begin
        if (expired) begin
          load = 1'b1;
          if (refs_left_q != '0) begin
            issue       = ISS_REFRESH;
            load_val    = TW'(N_RC - 1);
            refs_left_d = refs_left_q - 1'b1;
          end else begin
            issue    = ISS_MODE;
            load_val = TW'(N_MRD - 1);
            step_d   = ST_MODE_WAIT;
          end
        end
      end
      ST_MODE_WAIT: begin
        if (expired) begin
          finish = 1'b1;
          step_d = ST_READY;
        end
      end
      default: begin
        step_d = ST_READY;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q      <= ST_QUIET;
      refs_left_q <= '0;
    end else begin
      step_q      <= step_d;
      refs_left_q <= refs_left_d;
    end
  end

endmodule

// File: rtl/sdram_init_cmdgen.sv
module sdram_init_cmdgen
  import sdram_init_pkg::*;
#(
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DQM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  issue_e            issue,
  input  logic              finish,
  input  logic [2:0]        mode_bl,
  input  logic              mode_interleave,
  input  logic              mode_cl3,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              init_done
);

  logic [ROW_W-1:0] mode_word;
  logic [ROW_W-1:0] prea_word;
  logic [ROW_W-1:0] addr_d;
  pins_t            pins_d;

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = mode_bl;
    mode_word[3]   = mode_interleave;
    mode_word[6:4] = mode_cl3 ? 3'd3 : 3'd2;
    prea_word      = '0;
    prea_word[10]  = 1'b1;
    case (issue)
      ISS_PREA: addr_d = prea_word;
      ISS_MODE: addr_d = mode_word;
      default:  addr_d = '0;
    endcase
    pins_d = issue_pins(issue);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= PINS_NOP;
      addr      <= '0;
      ba        <= '0;
      cke       <= 1'b1;
      dqm       <= '1;
      init_done <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= pins_d;
      addr      <= addr_d;
      ba        <= '0;
      cke       <= 1'b1;
      dqm       <= '1;
      init_done <= init_done | finish;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_QUIET_NS    = 500000,
  parameter int unsigned T_RP_NS       = 20,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_MRD_NS      = 20,
  parameter int unsigned REFRESH_COUNT = 8,
  parameter int unsigned ROW_W         = 12,
  parameter int unsigned BANK_W        = 2,
  parameter int unsigned DQM_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_bl,
  input  logic              mode_interleave,
  input  logic              mode_cl3,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              init_done
);

  localparam int unsigned N_QUIET = ns_to_cycles(T_QUIET_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RP    = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RC    = ns_to_cycles(T_RC_NS, CLK_PERIOD_PS);
  localparam int unsigned N_MRD   = ns_to_cycles(T_MRD_NS, CLK_PERIOD_PS);
  localparam int unsigned GAP_A   = (N_QUIET > N_RP) ? N_QUIET : N_RP;
  localparam int unsigned GAP_B   = (N_RC > N_MRD) ? N_RC : N_MRD;
  localparam int unsigned GAP_MAX = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int unsigned TW      = $clog2(GAP_MAX + 1);
  localparam int unsigned RW      = $clog2(REFRESH_COUNT + 1);

  logic          expired;
  logic          load;
  logic [TW-1:0] load_val;
  issue_e        issue;
  logic          finish;

  sdram_init_timer #(
    .TW       (TW),
    .RST_LOAD (N_QUIET - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sdram_init_ctrl #(
    .TW            (TW),
    .RW            (RW),
    .N_RP          (N_RP),
    .N_RC          (N_RC),
    .N_MRD         (N_MRD),
    .REFRESH_COUNT (REFRESH_COUNT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .expired  (expired),
    .load     (load),
    .load_val (load_val),
    .issue    (issue),
    .finish   (finish)
  );

  sdram_init_cmdgen #(
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W),
    .DQM_W  (DQM_W)
  ) u_cmdgen (
    .clk             (clk),
    .rst             (rst),
    .issue           (issue),
    .finish          (finish),
    .mode_bl         (mode_bl),
    .mode_interleave (mode_interleave),
    .mode_cl3        (mode_cl3),
    .cke             (cke),
    .cs_n            (cs_n),
    .ras_n           (ras_n),
    .cas_n           (cas_n),
    .we_n            (we_n),
    .ba              (ba),
    .addr            (addr),
    .dqm             (dqm),
    .init_done       (init_done)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_QUIET_NS    = 500000,
  parameter int unsigned T_RP_NS       = 20,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_MRD_NS      = 20,
  parameter int unsigned REFRESH_COUNT = 8,
  parameter int unsigned ROW_W         = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] addr,
  input logic             init_done
);

  localparam int unsigned N_QUIET = ns_to_cycles(T_QUIET_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RP    = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RC    = ns_to_cycles(T_RC_NS, CLK_PERIOD_PS);
  localparam int unsigned N_MRD   = ns_to_cycles(T_MRD_NS, CLK_PERIOD_PS);

  localparam logic [2:0] K_NONE = 3'd0;
  localparam logic [2:0] K_PRE  = 3'd1;
  localparam logic [2:0] K_REF  = 3'd2;
  localparam logic [2:0] K_MODE = 3'd3;

  pins_t pins;
  logic  is_nop, is_pre, is_ref, is_mode;
  logic [2:0]  last_q;
  int unsigned gap_q;
  int unsigned refs_q;

  assign pins    = {cs_n, ras_n, cas_n, we_n};
  assign is_nop  = (pins == PINS_NOP);
  assign is_pre  = (pins == PINS_PREA);
  assign is_ref  = (pins == PINS_REF);
  assign is_mode = (pins == PINS_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= K_NONE;
      gap_q  <= 0;
      refs_q <= 0;
    end else begin
      if (!is_nop) begin
        gap_q  <= 1;
        last_q <= is_pre ? K_PRE : is_ref ? K_REF : is_mode ? K_MODE : K_NONE;
      end else if (gap_q != 32'hFFFF_FFFF) begin
        gap_q <= gap_q + 1;
      end
      if (is_ref) refs_q <= refs_q + 1;
    end
  end

  // R2
  quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (last_q == K_NONE && gap_q == N_QUIET));

  // R3
  prea_a10_chk: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> addr[10]);

  // R4
  rp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (is_ref && last_q == K_PRE) |-> gap_q == N_RP);

  // R5
  rc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (is_ref && last_q == K_REF) |-> gap_q == N_RC);

  // R5
  ref_addr_chk: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> addr == '0);

  // R5
  ref_count_chk: assert property (@(posedge clk) disable iff (rst)
    is_mode |-> refs_q == REFRESH_COUNT);

  // R6
  mode_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_mode |-> (last_q == K_REF && gap_q == N_RC));

  // R6
  mode_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    is_mode |-> addr[ROW_W-1:7] == '0);

  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (last_q == K_MODE && gap_q == N_MRD));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .T_QUIET_NS    (T_QUIET_NS),
  .T_RP_NS       (T_RP_NS),
  .T_RC_NS       (T_RC_NS),
  .T_MRD_NS      (T_MRD_NS),
  .REFRESH_COUNT (REFRESH_COUNT),
  .ROW_W         (ROW_W)
) u_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

  localparam int PERIOD_PS = 4000;
  localparam int QUIET_NS  = 200;
  localparam int RP_NS     = 20;
  localparam int RC_NS     = 70;
  localparam int MRD_NS    = 15;
  localparam int NREF      = 8;

  function automatic int ceil_cyc(input int ns);
    int c;
    c = (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int NQ   = (QUIET_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int NRP  = (RP_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int NRC  = (RC_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int NMRD = (MRD_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int EP   = NQ;
  localparam int EM   = EP + NRP + NREF * NRC;
  localparam int ED   = EM + NMRD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_bl = 3'd0;
  logic        mode_interleave = 1'b0;
  logic        mode_cl3 = 1'b0;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [7:0]  dqm;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  sdram_init_seq #(
    .CLK_PERIOD_PS (PERIOD_PS),
    .T_QUIET_NS    (QUIET_NS),
    .T_RP_NS       (RP_NS),
    .T_RC_NS       (RC_NS),
    .T_MRD_NS      (MRD_NS),
    .REFRESH_COUNT (NREF),
    .ROW_W         (12),
    .BANK_W        (2),
    .DQM_W         (8)
  ) uut (
    .clk (clk), .rst (rst),
    .mode_bl (mode_bl), .mode_interleave (mode_interleave), .mode_cl3 (mode_cl3),
    .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .ba (ba), .addr (addr), .dqm (dqm), .init_done (init_done)
  );

  function automatic logic [27:0] now_vec();
    return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, dqm, init_done};
  endfunction

  function automatic logic [27:0] exp_vec(input int kind, input logic [11:0] a,
                                          input logic done);
    logic [3:0] p;
    case (kind)
      1:       p = 4'b0010;
      2:       p = 4'b0001;
      3:       p = 4'b0000;
      default: p = 4'b0111;
    endcase
    return {1'b1, p, 2'b00, a, 8'hFF, done};
  endfunction

  function automatic int kind_at(input int e);
    if (e == EP) return 1;
    if (e == EM) return 3;
    if (e >= EP + NRP && e < EM && ((e - EP - NRP) % NRC) == 0) return 2;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [27:0] act, input logic [27:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [2:0] bl, input logic bt, input logic cl3,
                         input int abort_at);
    logic [11:0] mw;
    mode_bl = bl; mode_interleave = bt; mode_cl3 = cl3;
    mw = {5'b0, (cl3 ? 3'd3 : 3'd2), bt, bl};
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", now_vec(), exp_vec(0, 12'h000, 1'b0));
    rst = 1'b0;
    for (int e = 1; e <= ED + 3; e++) begin
      int k;
      logic [11:0] a;
      string tag;
      @(posedge clk);
      @(negedge clk);
      k = kind_at(e);
      a = (k == 1) ? 12'h400 : (k == 3) ? mw : 12'h000;
      if (e >= ED) tag = "R10";
      else if (k == 1) tag = "R3";
      else if (k == 2) tag = (e == EP + NRP) ? "R4" : "R5";
      else if (k == 3) tag = "R6";
      else if (e < EP) tag = "R2";
      else tag = "R12";
      chk(tag, now_vec(), exp_vec(k, a, (e >= ED)));
      if (k == 3) begin
        chk("R7", {25'd0, addr[2:0]}, {25'd0, bl});
        chk("R8", {27'd0, addr[3]}, {27'd0, bt});
        chk("R9", {25'd0, addr[6:4]}, {25'd0, (cl3 ? 3'd3 : 3'd2)});
      end
      if (abort_at != 0 && e == abort_at - 1) begin
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11", now_vec(), exp_vec(0, 12'h000, 1'b0));
        return;
      end
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    logic [2:0] codes [5];
    codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
    // R12: bench-side rounding agrees with the localparams used for the schedule
    nchk++;
    if (ceil_cyc(RC_NS) != 18 || NRC != 18 || ceil_cyc(RP_NS) != 5) begin
      nfail++;
      $display("FAIL R12 actual=%0d expected=18", ceil_cyc(RC_NS));
    end
    for (int i = 0; i < 5; i++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
          run_seq(codes[i], b[0], c[0], 0);
    run_seq(3'd2, 1'b0, 1'b1, EP);             // R11 at precharge edge
    run_seq(3'd3, 1'b1, 1'b0, EP + NRP + 3 * NRC); // R11 at a refresh edge
    run_seq(3'd1, 1'b0, 1'b0, EM);             // R11 at mode-load edge
    run_seq(3'd7, 1'b1, 1'b1, 0);              // full restart after aborts
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

endmodule